// File: doc/BRIEF.md
# Programmable Raster Sync Timer

This block produces the three timing strobes of a raster video stream: a frame sync (`vsync`), a line sync (`hsync`) and a data-enable (`de`). It also provides a pixel index and a line index for a pattern source placed after it. The frame sync is programmed entirely in pixel clocks. An initial delay runs once after the block is enabled. After that, a high phase and a low phase alternate for as long as the block stays enabled, and each rising edge of `vsync` marks a frame start.

The line sync and the data-enable are two independent pulse trains. At every frame start each train waits its own delay, measured in pixel clocks from that frame start. It then emits a fixed number of pulses, each made of a high time and a low time, and stays low until the next frame start. A train that has not finished when a new frame starts is cut off and begins again.

Software programs the timing through a simple write port into a set of shadow registers. The running frame keeps its timing, and new values take effect at the next frame start. Lowering `enable` returns every output and counter to zero. Raising it again restarts from the initial delay.

Top module: `vid_sync_timer`

## Requirements
- R1: After `enable` is sampled high, `vsync` stays low for D cycles (D = programmed frame-sync delay). It is then high for H cycles and low for L cycles, and this H/L cycle repeats while `enable` stays high.
- R2: With D = 0, `vsync` is high in the first cycle after the edge that samples `enable` high.
- R3: Counting frame-relative cycles from 0 at the first `vsync`-high cycle, `hsync` first rises at cycle HD. Each pulse is high for HH cycles and low for HL cycles, and exactly HC pulses occur before `hsync` stays low. HC = 0 yields no pulse. HH and HL must be at least 1.
- R4: `de` follows the same rule as `hsync`, using its own delay DD, high time DH, low time DL and count DC.
- R5: Both trains restart at every frame start, even when the previous frame's train is still running.
- R6: While `de` is high, `pix_x` is the cycle index within the current `de` pulse, starting at 0. `line_y` is the index of that pulse within the frame, starting at 0. `pix_x` is 0 while `de` is low.
- R7: In the cycle after an edge that samples `enable` low, `vsync`, `hsync`, `de`, `pix_x` and `line_y` are all 0. This is also their state after reset.
- R8: A register write changes nothing in the frame that is running. The new values govern the next frame, beginning at its frame start.
- R9: A write with `wr_en` high loads `wr_data` into the register selected by `wr_addr`. The map is: 0 = D, 1 = H, 2 = L, 3 = HD, 4 = HH, 5 = HL, 6 = HC, 7 = DD, 8 = DH, 9 = DL, 10 = DC. The 16-bit fields HH, HL, HC, DH, DL and DC take the low bits of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator while high; clears it while low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register select |
| wr_data | input | VW (24) | Register write value |
| vsync | output | 1 | Frame sync |
| hsync | output | 1 | Line sync |
| de | output | 1 | Active-pixel enable |
| pix_x | output | HW (16) | Pixel index in the current active line |
| line_y | output | HW (16) | Active line index in the current frame |

## Verification
The bench builds the block with its default widths: 24-bit frame fields and 16-bit line fields. It programs small rasters of 12 or 8 pixels per line and 7 or 5 lines per frame, so that several whole frames, frame wraps and train restarts all fit in a few hundred cycles. One configuration sets the line-sync count far above the line count of the frame, so that a frame start cuts the train off. The same configuration sets the data-enable count to zero. A further run rewrites the whole timing in the middle of a frame, which exercises the switchover at the frame boundary.

// File: rtl/vid_sync_timer.sv
module vid_sync_timer #(
  parameter int VW = 24,
  parameter int HW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [VW-1:0] wr_data,
  output logic          vsync,
  output logic          hsync,
  output logic          de,
  output logic [HW-1:0] pix_x,
  output logic [HW-1:0] line_y
);

  typedef enum logic [1:0] {V_IDLE, V_WAIT, V_HIGH, V_LOW} vst_t;
  typedef enum logic [1:0] {T_OFF, T_WAIT, T_HI, T_LO} tst_t;

  function automatic logic [VW-1:0] dec1(input logic [VW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  logic [VW-1:0] sh_vdly, sh_vhi, sh_vlo, ac_vlo;
  logic [VW-1:0] sh_tdly [2];
  logic [HW-1:0] sh_thi [2], sh_tlo [2], sh_tcnt [2];
  logic [HW-1:0] ac_thi [2], ac_tlo [2];

  vst_t          vst;
  logic [VW-1:0] vrem;
  logic          fs_go;
  logic [1:0]    tout, tend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_vdly <= '0;
      sh_vhi  <= '0;
      sh_vlo  <= '0;
      for (int i = 0; i < 2; i++) begin
        sh_tdly[i] <= '0;
        sh_thi[i]  <= '0;
        sh_tlo[i]  <= '0;
        sh_tcnt[i] <= '0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0):  sh_vdly    <= wr_data;
        AW'(1):  sh_vhi     <= wr_data;
        AW'(2):  sh_vlo     <= wr_data;
        AW'(3):  sh_tdly[0] <= wr_data;
        AW'(4):  sh_thi[0]  <= wr_data[HW-1:0];
        AW'(5):  sh_tlo[0]  <= wr_data[HW-1:0];
        AW'(6):  sh_tcnt[0] <= wr_data[HW-1:0];
        AW'(7):  sh_tdly[1] <= wr_data;
        AW'(8):  sh_thi[1]  <= wr_data[HW-1:0];
        AW'(9):  sh_tlo[1]  <= wr_data[HW-1:0];
        AW'(10): sh_tcnt[1] <= wr_data[HW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    fs_go = 1'b0;
    if (enable) begin
      case (vst)
        V_IDLE:  fs_go = (sh_vdly == '0);
        V_WAIT:  fs_go = (vrem == '0);
        V_LOW:   fs_go = (vrem == '0);
        default: fs_go = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_vlo <= '0;
      for (int i = 0; i < 2; i++) begin
        ac_thi[i] <= '0;
        ac_tlo[i] <= '0;
      end
    end else if (!enable || fs_go) begin
      ac_vlo <= sh_vlo;
      for (int i = 0; i < 2; i++) begin
        ac_thi[i] <= sh_thi[i];
        ac_tlo[i] <= sh_tlo[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vst  <= V_IDLE;
      vrem <= '0;
    end else if (!enable) begin
      vst  <= V_IDLE;
      vrem <= '0;
    end else if (fs_go) begin
      vst  <= V_HIGH;
      vrem <= dec1(sh_vhi);
    end else begin
      case (vst)
        V_IDLE: begin
          vst  <= V_WAIT;
          vrem <= sh_vdly - 1'b1;
        end
        V_HIGH: begin
          if (vrem == '0) begin
            vst  <= V_LOW;
            vrem <= dec1(ac_vlo);
          end else begin
            vrem <= vrem - 1'b1;
          end
        end
        default: vrem <= vrem - 1'b1;
      endcase
    end
  end

  assign vsync = (vst == V_HIGH);

  for (genvar g = 0; g < 2; g++) begin : g_train
    tst_t          tst;
    logic [VW-1:0] trem;
    logic [HW-1:0] tleft;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tst   <= T_OFF;
        trem  <= '0;
        tleft <= '0;
      end else if (!enable) begin
        tst   <= T_OFF;
        trem  <= '0;
        tleft <= '0;
      end else if (fs_go) begin
        tleft <= sh_tcnt[g] - 1'b1;
        if (sh_tcnt[g] == '0) begin
          tst  <= T_OFF;
          trem <= '0;
        end else if (sh_tdly[g] == '0) begin
          tst  <= T_HI;
          trem <= dec1(VW'(sh_thi[g]));
        end else begin
          tst  <= T_WAIT;
          trem <= sh_tdly[g] - 1'b1;
        end
      end else begin
        case (tst)
          T_WAIT: begin
            if (trem == '0) begin
              tst  <= T_HI;
              trem <= dec1(VW'(ac_thi[g]));
            end else trem <= trem - 1'b1;
          end
          T_HI: begin
            if (trem == '0) begin
              tst  <= T_LO;
              trem <= dec1(VW'(ac_tlo[g]));
            end else trem <= trem - 1'b1;
          end
          T_LO: begin
            if (trem == '0) begin
              if (tleft == '0) tst <= T_OFF;
              else begin
                tst   <= T_HI;
                tleft <= tleft - 1'b1;
                trem  <= dec1(VW'(ac_thi[g]));
              end
            end else trem <= trem - 1'b1;
          end
          default: ;
        endcase
      end
    end

    assign tout[g] = (tst == T_HI);
    assign tend[g] = (tst == T_HI) && (trem == '0);
  end

  assign hsync = tout[0];
  assign de    = tout[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_x  <= '0;
      line_y <= '0;
    end else if (!enable) begin
      pix_x  <= '0;
      line_y <= '0;
    end else begin
      if (fs_go)        line_y <= '0;
      else if (tend[1]) line_y <= line_y + 1'b1;
      if (!fs_go && de && !tend[1]) pix_x <= pix_x + 1'b1;
      else                          pix_x <= '0;
    end
  end

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!vsync && !hsync && !de && pix_x == '0 && line_y == '0));

  a_r1_vs_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> $past(enable));

  a_r6_pix_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> pix_x == '0);

  a_r6_pix_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && !$rose(vsync)) |-> pix_x == $past(pix_x) + 1'b1);

  a_r6_line_zero_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> line_y == '0);

endmodule

// File: tb/vid_sync_timer_tb.sv
module vid_sync_timer_tb;

  localparam int VW = 24;
  localparam int HW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [VW-1:0] wr_data = '0;
  logic          vsync, hsync, de;
  logic [HW-1:0] pix_x, line_y;

  always #2.5 clk = ~clk;

  vid_sync_timer #(.VW(VW), .HW(HW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .vsync(vsync), .hsync(hsync),
    .de(de), .pix_x(pix_x), .line_y(line_y));

  typedef struct {
    int vd, vh, vl, hd, hh, hl, hc, dd, dh, dl, dc;
  } cfg_t;

  typedef struct {
    bit    vs, hs, de;
    int    x, y;
    string tv, th, td;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void train(input longint f, input int d, input int h,
                                input int l, input int c, output bit on,
                                output int p, output int k);
    longint r;
    on = 0; p = 0; k = 0;
    if (f < d) return;
    r = f - d;
    if (r >= longint'(c) * (h + l)) return;
    p = int'(r % (h + l));
    k = int'(r / (h + l));
    on = (p < h);
  endfunction

  task automatic push_win(input cfg_t c, input int d, input int n,
                          input string tv, input string th, input string td);
    for (int t = 0; t < n; t++) begin
      item_t  it;
      longint f;
      int     p, k;
      bit     on;
      it.tv = tv; it.th = th; it.td = td;
      it.vs = 0; it.hs = 0; it.de = 0; it.x = 0; it.y = 0;
      if (t >= d) begin
        f = (t - d) % (c.vh + c.vl);
        it.vs = (f < c.vh);
        train(f, c.hd, c.hh, c.hl, c.hc, on, p, k);
        it.hs = on;
        train(f, c.dd, c.dh, c.dl, c.dc, on, p, k);
        it.de = on;
        if (on) begin
          it.x = p;
          it.y = k;
        end
      end
      q.push_back(it);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(vsync == it.vs, it.tv, "vsync", vsync, it.vs);
      check(hsync == it.hs, it.th, "hsync", hsync, it.hs);
      check(de == it.de, it.td, "de", de, it.de);
      if (it.de) begin
        check(pix_x == it.x, "R6", "pix_x", pix_x, it.x);
        check(line_y == it.y, "R6", "line_y", line_y, it.y);
      end
    end
  end

  task automatic wr(input int a, input int v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = AW'(a);
    wr_data = VW'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R9: register map used by every configuration load
  task automatic load(input cfg_t c);
    wr(0, c.vd); wr(1, c.vh); wr(2, c.vl);
    wr(3, c.hd); wr(4, c.hh); wr(5, c.hl); wr(6, c.hc);
    wr(7, c.dd); wr(8, c.dh); wr(9, c.dl); wr(10, c.dc);
  endtask

  task automatic expect_quiet(input string why);
    check(vsync == 0, "R7", {why, " vsync"}, vsync, 0);
    check(hsync == 0, "R7", {why, " hsync"}, hsync, 0);
    check(de == 0, "R7", {why, " de"}, de, 0);
    check(pix_x == 0, "R7", {why, " pix_x"}, pix_x, 0);
    check(line_y == 0, "R7", {why, " line_y"}, line_y, 0);
  endtask

  task automatic stop_gen();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    expect_quiet("after disable");
  endtask

  function automatic void summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cfg_t ca, cb, cc;
    // 12 px/line (6 act, 2 fp, 1 sync, 3 bp), 7 lines (3 act, 1 fp, 1 sync, 2 bp)
    ca = '{vd: 3, vh: 12, vl: 72, hd: 0, hh: 1, hl: 11, hc: 7,
           dd: 40, dh: 6, dl: 6, dc: 3};
    // 8 px/line (4 act, 1 fp, 2 sync, 1 bp), 5 lines (2 act, 1 fp, 1 sync, 1 bp)
    cb = '{vd: 0, vh: 8, vl: 32, hd: 0, hh: 2, hl: 6, hc: 5,
           dd: 19, dh: 4, dl: 4, dc: 2};
    // zero delay, overlong line-sync train, no data-enable
    cc = ca;
    cc.vd = 0; cc.hd = 5; cc.hc = 100; cc.dc = 0;

    repeat (3) @(negedge clk);
    expect_quiet("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_quiet("after reset");

    // R1 R3 R4 R6 R9: delayed start, three full frames
    load(ca);
    @(negedge clk);
    enable = 1'b1;
    #1 push_win(ca, ca.vd, ca.vd + 3 * 84, "R1", "R3", "R4");
    wait (q.size() == 0);
    stop_gen();

    // R2 R5: zero delay, line-sync cut at frame start, DC = 0
    load(cc);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(vsync == 1, "R2", "first-cycle vsync", vsync, 1);
    #1 push_win(cc, 0, 2 * 84, "R2", "R5", "R4");
    // first item (t=0) already consumed by monitor? drop it to stay aligned
    void'(q.pop_front());
    wait (q.size() == 0);
    stop_gen();

    // R8: rewrite all timing mid-frame, switch at the next frame start
    load(ca);
    @(negedge clk);
    enable = 1'b1;
    #1 begin
      push_win(ca, ca.vd, ca.vd + 84, "R8", "R8", "R8");
      push_win(cb, 0, 3 * 40, "R8", "R8", "R8");
    end
    repeat (30) @(negedge clk);
    load(cb);
    wait (q.size() == 0);
    stop_gen();

    // R7: re-enable restarts from the initial delay
    @(negedge clk);
    enable = 1'b1;
    #1 push_win(cb, cb.vd, 45, "R7", "R7", "R7");
    wait (q.size() == 0);
    stop_gen();

    done = 1;
    summary();
    $finish;
  end

endmodule